// File: doc/BRIEF.md
# Fixed-Frequency Buck Switch PWM Controller

This block builds the switching periods of a synchronous step-down converter in the digital clock domain. A phase counter sets the period length and also serves as the ramp. At every period start the block samples an error word from the loop filter and limits it to a legal duty. It then drives a high-side gate enable from phase zero until the phase reaches that duty. The low-side gate enable follows for the rest of the period, and a dead-time gap separates the two enables on both edges.

A peak current-limit flag ends the high-side pulse at once. The low side then stays on until a second flag reports that the inductor current has fallen below the low-side limit. No high-side pulse starts while that hold is active. An enable input and a fault-inhibit input stop all switching at once. The next period then starts cleanly, and it starts on the first clock after switching is allowed again.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: `cyc_start` is high for one cycle at phase 0 of every period. Periods are `per_cfg` clocks long, limited to the range 25 to 100, and `per_cfg` is sampled only when a period starts.
- R2: The high-side enable rises only in a cycle where `cyc_start` is high. It stays high for phases 0 to duty-1, where duty is the error word sampled at the start of that period.
- R3: An error word of 0 gives no high-side pulse. A non-zero word below 4 gives 4 cycles. A word at or above period minus 4 gives period minus 4 cycles, which is the maximum duty.
- R4: The two enables are never high together. In normal operation the low side is high for phases duty+2 up to period-3, so each edge is separated by 2 dead cycles.
- R5: If `ilim` is sampled high while the high side is on, the high side is low from the next cycle. The low side then comes on after the dead time and stays on across period starts, with no high-side pulse, until `ls_clr` is sampled high. The high side resumes at the first period start after that.
- R6: While `en` is low or `inhibit` is high, both enables are low in the same cycle and the current-limit hold is cleared. The first clock edge with switching allowed starts a new period.
- R7: During reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Switching enable |
| inhibit | input | 1 | Fault inhibit, stops switching while high |
| per_cfg | input | 8 | Period length in clocks |
| err_word | input | 8 | Duty demand from the loop filter, in clocks |
| ilim | input | 1 | High-side peak current-limit flag |
| ls_clr | input | 1 | Low-side current has fallen below its limit |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| cyc_start | output | 1 | Period start strobe |

## Verification
A vector table sweeps the error word across several kinds of value: zero, values inside the duty range, values below the minimum on-time, the value one below maximum duty, exactly maximum duty, and full scale. It also sweeps the period across in-range, below-range and above-range settings. For each entry the bench measures the period length, the high-side count and the low-side count. Together these separate a correct duty clamp from a wrong clamp order and from an off-by-one in the dead-time window. Directed runs then cover the rest. One cuts a pulse with the current-limit flag and holds the low side across a period start until release. Another drops the enable and the inhibit in the middle of a pulse or a low-side interval. These runs check the cycle of termination, the dead gap, the suppressed pulse and the immediate restart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic hs;
    logic ls;
  } gate_pair_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW      = 8,
  parameter int PER_MIN = 25,
  parameter int PER_MAX = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] per_cfg,
  output logic [CW-1:0] ph_nx,
  output logic          start_nx,
  output logic [CW-1:0] per_use,
  output logic          strobe
);
  localparam logic [CW-1:0] PMIN = CW'(PER_MIN);
  localparam logic [CW-1:0] PMAX = CW'(PER_MAX);

  logic [CW-1:0] ph_q, per_q, per_clamp;
  logic          started_q, wrap;

  always_comb begin
    if (per_cfg < PMIN)      per_clamp = PMIN;
    else if (per_cfg > PMAX) per_clamp = PMAX;
    else                     per_clamp = per_cfg;
    wrap     = !started_q || (ph_q == per_q - CW'(1));
    start_nx = run && wrap;
    ph_nx    = (!run || wrap) ? '0 : ph_q + CW'(1);
    per_use  = wrap ? per_clamp : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= '0;
      per_q     <= PMIN;
      started_q <= 1'b0;
      strobe    <= 1'b0;
    end else begin
      ph_q      <= ph_nx;
      started_q <= run;
      strobe    <= start_nx;
      if (start_nx) per_q <= per_use;
    end
  end

  p_period_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (ph_q < per_q));
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
  parameter int CW      = 8,
  parameter int MIN_ON  = 4,
  parameter int MIN_OFF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start_nx,
  input  logic [CW-1:0] err,
  input  logic [CW-1:0] per_use,
  output logic [CW-1:0] duty_use
);
  localparam logic [CW-1:0] MON  = CW'(MIN_ON);
  localparam logic [CW-1:0] MOFF = CW'(MIN_OFF);

  logic [CW-1:0] duty_q, duty_new, duty_max;

  always_comb begin
    duty_max = per_use - MOFF;
    if (err == '0)           duty_new = '0;
    else if (err < MON)      duty_new = MON;
    else if (err > duty_max) duty_new = duty_max;
    else                     duty_new = err;
    duty_use = start_nx ? duty_new : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         duty_q <= '0;
    else if (!run)      duty_q <= '0;
    else if (start_nx)  duty_q <= duty_new;
  end

  p_duty_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (duty_q <= per_use - MOFF) || start_nx);
endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq
  import pwm_pkg::*;
#(
  parameter int CW   = 8,
  parameter int DEAD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start_nx,
  input  logic [CW-1:0] ph_nx,
  input  logic [CW-1:0] duty_use,
  input  logic [CW-1:0] per_use,
  input  logic          ilim,
  input  logic          lclr,
  output gate_pair_t    gq
);
  localparam int           IW  = $clog2(DEAD + 1);
  localparam logic [IW-1:0] DQ = IW'(DEAD);
  localparam logic [CW:0]   DX = (CW+1)'(DEAD);

  gate_pair_t    gn;
  logic [IW-1:0] hs_idle_q, ls_idle_q, hs_idle_nx, ls_idle_nx;
  logic          hold_q, blk_q, hold_nx, blk_nx, cut;
  logic          hs_win, ls_win, hs_off_long, ls_off_long;
  logic [CW:0]   ph_x, duty_x, per_x;

  always_comb begin
    ph_x   = {1'b0, ph_nx};
    duty_x = {1'b0, duty_use};
    per_x  = {1'b0, per_use};
    cut    = ilim && gq.hs;
    hold_nx = run && (cut || (hold_q && !lclr));
    blk_nx  = run && (cut || (blk_q && !(start_nx && !hold_nx)));
    hs_win  = ph_x < duty_x;
    ls_win  = (ph_x >= duty_x + DX) && (ph_x + DX < per_x);
    hs_off_long = (hs_idle_q >= DQ);
    ls_off_long = (ls_idle_q >= DQ);
    gn.hs = run && hs_win && !blk_nx && (gq.hs || (start_nx && ls_off_long));
    gn.ls = run && (ls_win || hold_nx) && hs_off_long && !gn.hs;
    hs_idle_nx = gn.hs ? '0 : ((hs_idle_q == DQ) ? DQ : hs_idle_q + IW'(1));
    ls_idle_nx = gn.ls ? '0 : ((ls_idle_q == DQ) ? DQ : ls_idle_q + IW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gq        <= '0;
      hs_idle_q <= DQ;
      ls_idle_q <= DQ;
      hold_q    <= 1'b0;
      blk_q     <= 1'b0;
    end else begin
      gq        <= gn;
      hs_idle_q <= hs_idle_nx;
      ls_idle_q <= ls_idle_nx;
      hold_q    <= hold_nx;
      blk_q     <= blk_nx;
    end
  end

  p_bbm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gq.hs && gq.ls));
  p_dead_ls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gq.ls) |-> !$past(gq.hs));
  p_dead_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gq.hs) |-> !$past(gq.ls));
  p_ilim_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ilim && gq.hs) |=> !gq.hs);
  p_hold_ls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold_q && !lclr && gq.ls) |=> gq.ls);
  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!gq.hs && !gq.ls));
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import pwm_pkg::*;
#(
  parameter int CW      = 8,
  parameter int PER_MIN = 25,
  parameter int PER_MAX = 100,
  parameter int MIN_ON  = 4,
  parameter int MIN_OFF = 4,
  parameter int DEAD    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          inhibit,
  input  logic [CW-1:0] per_cfg,
  input  logic [CW-1:0] err_word,
  input  logic          ilim,
  input  logic          ls_clr,
  output logic          hs_gate,
  output logic          ls_gate,
  output logic          cyc_start
);
  logic          run, start_nx;
  logic [CW-1:0] ph_nx, per_use, duty_use;
  gate_pair_t    gq;

  assign run = en && !inhibit;

  pwm_timebase #(.CW(CW), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .per_cfg(per_cfg),
    .ph_nx(ph_nx), .start_nx(start_nx), .per_use(per_use), .strobe(cyc_start)
  );

  pwm_duty #(.CW(CW), .MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF)) u_duty (
    .clk(clk), .rst_n(rst_n), .run(run), .start_nx(start_nx),
    .err(err_word), .per_use(per_use), .duty_use(duty_use)
  );

  pwm_gate_seq #(.CW(CW), .DEAD(DEAD)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .start_nx(start_nx), .ph_nx(ph_nx),
    .duty_use(duty_use), .per_use(per_use), .ilim(ilim), .lclr(ls_clr), .gq(gq)
  );

  assign hs_gate = gq.hs && run;
  assign ls_gate = gq.ls && run;

  p_hs_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> cyc_start);
endmodule

// File: tb/pwm_gate_ctrl_tb.sv
module pwm_gate_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n, en, inhibit, ilim, ls_clr;
  logic [7:0] per_cfg, err_word;
  logic       hs_gate, ls_gate, cyc_start;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwm_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .inhibit(inhibit), .per_cfg(per_cfg),
    .err_word(err_word), .ilim(ilim), .ls_clr(ls_clr),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .cyc_start(cyc_start)
  );

  // per_cfg, err_word, expected length, high-side cycles, low-side cycles
  localparam int NV = 11;
  localparam int VEC [NV][5] = '{
    '{ 50,  20,  50, 20, 26},
    '{ 50,   0,  50,  0, 46},
    '{ 50,   2,  50,  4, 42},
    '{ 50, 255,  50, 46,  0},
    '{ 50,  46,  50, 46,  0},
    '{ 50,  45,  50, 45,  1},
    '{100,  50, 100, 50, 46},
    '{ 25,  10,  25, 10, 11},
    '{ 10,   5,  25,  5, 16},
    '{200, 100, 100, 96,  0},
    '{100,   1, 100,  4, 92}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic skip(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Returns at a negedge where cyc_start is high, after measuring one period
  task automatic measure(output int len, output int hsn, output int lsn, output int ovl);
    len = 0; hsn = 0; lsn = 0; ovl = 0;
    do @(negedge clk); while (!cyc_start);
    do begin
      len++;
      if (hs_gate) hsn++;
      if (ls_gate) lsn++;
      if (hs_gate && ls_gate) ovl++;
      @(negedge clk);
    end while (!cyc_start);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len, hsn, lsn, ovl, cnt;
    rst_n = 1'b0; en = 1'b0; inhibit = 1'b0; ilim = 1'b0; ls_clr = 1'b0;
    per_cfg = 8'd50; err_word = 8'd20;
    skip(3);
    chk("R7 reset hs", int'(hs_gate), 0);
    chk("R7 reset ls", int'(ls_gate), 0);
    chk("R7 reset strobe", int'(cyc_start), 0);
    rst_n = 1'b1;
    skip(3);
    chk("R6 disabled strobe", int'(cyc_start), 0);
    en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      per_cfg  = 8'(VEC[i][0]);
      err_word = 8'(VEC[i][1]);
      measure(len, hsn, lsn, ovl);
      chk($sformatf("R1 period vec%0d", i), len, VEC[i][2]);
      chk($sformatf("R2 R3 high width vec%0d", i), hsn, VEC[i][3]);
      chk($sformatf("R4 low width vec%0d", i), lsn, VEC[i][4]);
      chk($sformatf("R4 overlap vec%0d", i), ovl, 0);
    end

    // Current limit: period 50, duty 30
    per_cfg = 8'd50; err_word = 8'd30;
    measure(len, hsn, lsn, ovl);
    chk("R2 hs on at phase 0", int'(hs_gate), 1);
    skip(5);
    ilim = 1'b1;
    @(negedge clk);
    ilim = 1'b0;
    chk("R5 cut next cycle", int'(hs_gate), 0);
    chk("R4 dead after cut 1", int'(ls_gate), 0);
    @(negedge clk);
    chk("R4 dead after cut 2", int'(ls_gate), 0);
    @(negedge clk);
    chk("R5 low side on after dead", int'(ls_gate), 1);
    do @(negedge clk); while (!cyc_start);
    chk("R5 held period no hs", int'(hs_gate), 0);
    chk("R5 low side held across start", int'(ls_gate), 1);
    skip(10);
    ls_clr = 1'b1;
    @(negedge clk);
    ls_clr = 1'b0;
    chk("R5 low side released", int'(ls_gate), 0);
    cnt = 0;
    do begin
      if (hs_gate) cnt++;
      @(negedge clk);
    end while (!cyc_start);
    chk("R5 no hs rest of period", cnt, 0);
    chk("R5 hs resumes at start", int'(hs_gate), 1);
    measure(len, hsn, lsn, ovl);
    chk("R5 normal period after release", hsn, 30);
    chk("R4 normal low after release", lsn, 16);

    // Enable drop in mid pulse
    skip(3);
    en = 1'b0;
    #1;
    chk("R6 hs off at once", int'(hs_gate), 0);
    chk("R6 ls off at once", int'(ls_gate), 0);
    skip(3);
    chk("R6 no strobe disabled", int'(cyc_start), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R6 restart strobe", int'(cyc_start), 1);
    chk("R6 restart hs", int'(hs_gate), 1);

    // Inhibit during low-side interval
    skip(40);
    chk("R4 low side mid period", int'(ls_gate), 1);
    inhibit = 1'b1;
    #1;
    chk("R6 inhibit ls off", int'(ls_gate), 0);
    skip(2);
    inhibit = 1'b0;
    @(negedge clk);
    chk("R6 inhibit restart strobe", int'(cyc_start), 1);
    measure(len, hsn, lsn, ovl);
    chk("R1 period after inhibit", len, 50);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule